// File: doc/BRIEF.md
# Carry-Save Shift-Add Multiplier Step

This block is one stage of a streaming multiplier that keeps its running sum in carry-save form. It takes three operand words through three valid/ready inputs and returns three result words through three valid/ready outputs. Two kinds of operation alternate under the control of an operation counter.

- A partial-product step passes the first operand through, shifts the multiplier operand right by one, and gates the multiplicand with the multiplier's low bit.
- A 3:2 reduction step produces the majority word and the shifted three-way XOR. It also retires the XOR's low bit as a finished product bit.

Finished bits collect in an internal bit buffer. They leave on a separate valid/ready output as fixed-size groups. When the operation budget runs out, the block flushes the carry-save state it just produced through a run of internal reduction iterations. Each iteration yields one more product bit. The counter then reloads and normal operation resumes.

Signed arithmetic and a final carry-propagate addition are not part of this block.

Top module: `csa_mul_step`

## Requirements
- R1: After a synchronous active-high reset, `p_vld`, `q_vld`, `r_vld` and `bits_vld` are 0, the bit buffer is empty and the counter holds the budget (default 74), so the first operation is a partial-product step.
- R2: An operation fires (`x_rdy`, `y_rdy`, `z_rdy` all 1 and all three inputs consumed) exactly when `x_vld`, `y_vld` and `z_vld` are 1, each output channel is free (its valid is 0 or its ready is 1), the bit buffer holds fewer bits than its capacity, and no flush is in progress.
- R3: The partial-product step is taken when the counter is even. It gives p = x, q = y >> 1 and r = (y[0] ? x : 0). The results appear on the outputs in the cycle after the fire.
- R4: The reduction step is taken when the counter is odd. It gives p = bitwise majority of x, y and z, q = (x ^ y ^ z) >> 1 and r = 0.
- R5: The counter decrements once per fired operation, so steps strictly alternate starting with a partial-product step. The p output therefore switches between pass-through and majority.
- R6: Each reduction step appends bit 0 of x ^ y ^ z to the bit buffer. A partial-product step appends nothing.
- R7: When a fire brings the counter to 0, the block runs 37 internal reduction iterations on the p, q and r words of that fire. Each iteration appends one bit and takes one cycle while the buffer has room. Inputs are stalled throughout. Afterwards the counter reloads to the budget.
- R8: Whenever the buffer holds at least 37 bits and the group output is free, the 37 oldest bits are removed and presented on `bits_dat`, with the oldest bit in bit 0.
- R9: A valid result on p, q, r or bits stays valid with unchanged data until its ready is seen high.
- R10: The bit buffer holds at most 74 bits. No operation fires and no flush iteration runs while it is full.
- R11: Right shifts fill the top bit with 0, so bit DW-1 of `q_dat` is 0 whenever `q_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_vld | input | 1 | First operand valid |
| x_rdy | output | 1 | First operand accepted |
| x_dat | input | DW | First operand (multiplicand / carry word) |
| y_vld | input | 1 | Second operand valid |
| y_rdy | output | 1 | Second operand accepted |
| y_dat | input | DW | Second operand (multiplier / sum word) |
| z_vld | input | 1 | Third operand valid |
| z_rdy | output | 1 | Third operand accepted |
| z_dat | input | DW | Third operand |
| p_vld | output | 1 | Pass-through / majority result valid |
| p_rdy | input | 1 | Consumer ready for p |
| p_dat | output | DW | Pass-through / majority result |
| q_vld | output | 1 | Shifted result valid |
| q_rdy | input | 1 | Consumer ready for q |
| q_dat | output | DW | Shifted multiplier / shifted XOR |
| r_vld | output | 1 | Selected-product result valid |
| r_rdy | input | 1 | Consumer ready for r |
| r_dat | output | DW | Gated multiplicand or zero |
| bits_vld | output | 1 | Product bit group valid |
| bits_rdy | input | 1 | Consumer ready for a bit group |
| bits_dat | output | GROUP | Finished product bits, oldest in bit 0 |

## Verification
Operands are tried as random words, as multipliers with bit 0 forced to 0 and to 1, as an all-ones multiplier and as three equal words. The forced low bit separates the two branches of the product gating. The all-ones multiplier exposes a shift that fails to fill with zero. Equal words make majority equal the operand and the XOR equal the operand, which catches swapped reduction terms. Runs with every consumer always ready cover several full budgets and flushes. Runs with random valid and ready exercise the stall rules. A long stall of the bit-group consumer drives the buffer to its capacity limit.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;
    typedef enum logic {
        OP_PARTIAL = 1'b0,
        OP_REDUCE  = 1'b1
    } op_mode_e;
endpackage

// File: rtl/csa_step_dp.sv
module csa_step_dp
    import csa_mul_pkg::*;
#(
    parameter int DW = 64
) (
    input  op_mode_e        mode,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [DW-1:0]   c,
    output logic [DW-1:0]   o1,
    output logic [DW-1:0]   o2,
    output logic [DW-1:0]   o3,
    output logic            sum_lsb
);
    logic [DW-1:0] sum3;
    logic [DW-1:0] maj3;

    always_comb begin
        sum3    = a ^ b ^ c;
        maj3    = (a & b) | (b & c) | (a & c);
        sum_lsb = sum3[0];
        unique case (mode)
            OP_PARTIAL: begin
                o1 = a;
                o2 = b >> 1;
                o3 = b[0] ? a : '0;
            end
            default: begin
                o1 = maj3;
                o2 = sum3 >> 1;
                o3 = '0;
            end
        endcase
    end
endmodule

// File: rtl/csa_op_seq.sv
module csa_op_seq
    import csa_mul_pkg::*;
#(
    parameter int BUDGET = 74,
    parameter int FLUSH  = 37
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    input  logic     flush_step,
    output op_mode_e mode,
    output logic     flush_active,
    output logic     flush_start
);
    localparam int CW = $clog2(BUDGET + 1);
    localparam int FW = $clog2(FLUSH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [FW-1:0] left;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        mode         = s_q.cnt[0] ? OP_REDUCE : OP_PARTIAL;
        flush_active = (s_q.left != '0);
        flush_start  = fire && (s_q.cnt == CW'(1));
        s_d          = s_q;
        if (fire) begin
            s_d.cnt = s_q.cnt - CW'(1);
            if (flush_start) begin
                s_d.left = FW'(FLUSH);
            end
        end else if (flush_step) begin
            s_d.left = s_q.left - FW'(1);
            if (s_q.left == FW'(1)) begin
                s_d.cnt = CW'(BUDGET);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt  <= CW'(BUDGET);
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R5: steps alternate between consecutive operations outside a flush
    p_alternate_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && !flush_start) |=> (mode != $past(mode)));

    // R7: no operation fires while a flush is pending
    p_no_fire_in_flush_r7: assert property (@(posedge clk) disable iff (rst)
        flush_active |-> !fire);
endmodule

// File: rtl/csa_bit_buf.sv
module csa_bit_buf #(
    parameter int CAP   = 74,
    parameter int GROUP = 37
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             push_bit,
    output logic             room,
    output logic             grp_vld,
    input  logic             grp_rdy,
    output logic [GROUP-1:0] grp_word
);
    localparam int NW = $clog2(CAP + 1);

    typedef struct packed {
        logic [CAP-1:0]   mem;
        logic [NW-1:0]    cnt;
        logic             vld;
        logic [GROUP-1:0] word;
    } buf_t;

    buf_t b_q, b_d;
    logic pop;

    always_comb begin
        room = (b_q.cnt < NW'(CAP));
        pop  = (b_q.cnt >= NW'(GROUP)) && (!b_q.vld || grp_rdy);
        b_d  = b_q;
        if (pop) begin
            b_d.word = b_q.mem[GROUP-1:0];
            b_d.vld  = 1'b1;
            b_d.mem  = b_q.mem >> GROUP;
            b_d.cnt  = b_q.cnt - NW'(GROUP);
        end else if (grp_rdy) begin
            b_d.vld = 1'b0;
        end
        if (push) begin
            b_d.mem[b_d.cnt] = push_bit;
            b_d.cnt          = b_d.cnt + NW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q.mem  <= '0;
            b_q.cnt  <= '0;
            b_q.vld  <= 1'b0;
            b_q.word <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign grp_vld  = b_q.vld;
    assign grp_word = b_q.word;

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        b_q.cnt <= NW'(CAP));

    p_push_room_r10: assert property (@(posedge clk) disable iff (rst)
        push |-> room);

    p_group_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (grp_vld && !grp_rdy) |=> (grp_vld && $stable(grp_word)));
endmodule

// File: rtl/csa_mul_step.sv
module csa_mul_step
    import csa_mul_pkg::*;
#(
    parameter int DW     = 64,
    parameter int BUDGET = 74,
    parameter int FLUSH  = 37,
    parameter int CAP    = 74,
    parameter int GROUP  = 37
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             x_vld,
    output logic             x_rdy,
    input  logic [DW-1:0]    x_dat,
    input  logic             y_vld,
    output logic             y_rdy,
    input  logic [DW-1:0]    y_dat,
    input  logic             z_vld,
    output logic             z_rdy,
    input  logic [DW-1:0]    z_dat,
    output logic             p_vld,
    input  logic             p_rdy,
    output logic [DW-1:0]    p_dat,
    output logic             q_vld,
    input  logic             q_rdy,
    output logic [DW-1:0]    q_dat,
    output logic             r_vld,
    input  logic             r_rdy,
    output logic [DW-1:0]    r_dat,
    output logic             bits_vld,
    input  logic             bits_rdy,
    output logic [GROUP-1:0] bits_dat
);
    typedef struct packed {
        logic          p_vld;
        logic          q_vld;
        logic          r_vld;
        logic [DW-1:0] p;
        logic [DW-1:0] q;
        logic [DW-1:0] r;
        logic [DW-1:0] f1;
        logic [DW-1:0] f2;
        logic [DW-1:0] f3;
    } top_t;

    top_t s_q, s_d;

    op_mode_e      mode;
    logic          flush_active, flush_start, flush_step;
    logic          room, go, push, push_bit;
    logic [DW-1:0] m1, m2, m3, n1, n2, n3;
    logic          m_lsb, n_lsb;

    csa_step_dp #(.DW(DW)) u_dp_main (
        .mode(mode), .a(x_dat), .b(y_dat), .c(z_dat),
        .o1(m1), .o2(m2), .o3(m3), .sum_lsb(m_lsb)
    );

    csa_step_dp #(.DW(DW)) u_dp_flush (
        .mode(OP_REDUCE), .a(s_q.f1), .b(s_q.f2), .c(s_q.f3),
        .o1(n1), .o2(n2), .o3(n3), .sum_lsb(n_lsb)
    );

    csa_op_seq #(.BUDGET(BUDGET), .FLUSH(FLUSH)) u_seq (
        .clk(clk), .rst(rst), .fire(go), .flush_step(flush_step),
        .mode(mode), .flush_active(flush_active), .flush_start(flush_start)
    );

    csa_bit_buf #(.CAP(CAP), .GROUP(GROUP)) u_buf (
        .clk(clk), .rst(rst), .push(push), .push_bit(push_bit), .room(room),
        .grp_vld(bits_vld), .grp_rdy(bits_rdy), .grp_word(bits_dat)
    );

    always_comb begin
        go = x_vld && y_vld && z_vld
          && (!s_q.p_vld || p_rdy)
          && (!s_q.q_vld || q_rdy)
          && (!s_q.r_vld || r_rdy)
          && room && !flush_active;
        flush_step = flush_active && room;
        push       = (go && (mode == OP_REDUCE)) || flush_step;
        push_bit   = flush_step ? n_lsb : m_lsb;

        s_d = s_q;
        if (go) begin
            s_d.p = m1;  s_d.q = m2;  s_d.r = m3;
            s_d.p_vld = 1'b1;
            s_d.q_vld = 1'b1;
            s_d.r_vld = 1'b1;
        end else begin
            if (p_rdy) s_d.p_vld = 1'b0;
            if (q_rdy) s_d.q_vld = 1'b0;
            if (r_rdy) s_d.r_vld = 1'b0;
        end
        if (go && flush_start) begin
            s_d.f1 = m1;  s_d.f2 = m2;  s_d.f3 = m3;
        end else if (flush_step) begin
            s_d.f1 = n1;  s_d.f2 = n2;  s_d.f3 = n3;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign x_rdy = go;
    assign y_rdy = go;
    assign z_rdy = go;
    assign p_vld = s_q.p_vld;
    assign q_vld = s_q.q_vld;
    assign r_vld = s_q.r_vld;
    assign p_dat = s_q.p;
    assign q_dat = s_q.q;
    assign r_dat = s_q.r;

    p_flush_stall_r7: assert property (@(posedge clk) disable iff (rst)
        flush_active |-> (!x_rdy && !y_rdy && !z_rdy));

    p_hold_p_r9: assert property (@(posedge clk) disable iff (rst)
        (p_vld && !p_rdy) |=> (p_vld && $stable(p_dat)));

    p_hold_q_r9: assert property (@(posedge clk) disable iff (rst)
        (q_vld && !q_rdy) |=> (q_vld && $stable(q_dat)));

    p_zero_fill_r11: assert property (@(posedge clk) disable iff (rst)
        q_vld |-> !q_dat[DW-1]);

    p_gate_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (go && (mode == OP_PARTIAL) && !y_dat[0]) |=> (r_dat == '0));

    p_reduce_r_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (go && (mode == OP_REDUCE)) |=> (r_dat == '0));
endmodule

// File: tb/csa_mul_step_bench.sv
`timescale 1ns/1ps
module csa_mul_step_bench;
    localparam int DW = 64;
    localparam int BUDGET = 74;
    localparam int FLUSH = 37;
    localparam int CAP = 74;
    localparam int GROUP = 37;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_vld = 0, y_vld = 0, z_vld = 0;
    logic x_rdy, y_rdy, z_rdy;
    logic [DW-1:0] x_dat = '0, y_dat = '0, z_dat = '0;
    logic p_vld, q_vld, r_vld, bits_vld;
    logic p_rdy = 0, q_rdy = 0, r_rdy = 0, bits_rdy = 0;
    logic [DW-1:0] p_dat, q_dat, r_dat;
    logic [GROUP-1:0] bits_dat;

    always #4 clk = ~clk;

    csa_mul_step #(.DW(DW), .BUDGET(BUDGET), .FLUSH(FLUSH), .CAP(CAP), .GROUP(GROUP)) u_csa_mul_step (
        .clk(clk), .rst(rst),
        .x_vld(x_vld), .x_rdy(x_rdy), .x_dat(x_dat),
        .y_vld(y_vld), .y_rdy(y_rdy), .y_dat(y_dat),
        .z_vld(z_vld), .z_rdy(z_rdy), .z_dat(z_dat),
        .p_vld(p_vld), .p_rdy(p_rdy), .p_dat(p_dat),
        .q_vld(q_vld), .q_rdy(q_rdy), .q_dat(q_dat),
        .r_vld(r_vld), .r_rdy(r_rdy), .r_dat(r_dat),
        .bits_vld(bits_vld), .bits_rdy(bits_rdy), .bits_dat(bits_dat)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    int cnt = BUDGET;
    int fl = 0;
    bit last_reduce = 0;
    logic [DW-1:0] f1 = '0, f2 = '0, f3 = '0;
    bit bq[$];
    bit m_pv = 0, m_qv = 0, m_rv = 0, m_bv = 0;
    logic [DW-1:0] m_p = '0, m_q = '0, m_r = '0;
    logic [GROUP-1:0] m_bw = '0;
    int words_model = 0;
    int words_dut = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    task automatic drive(input int phase);
        logic [DW-1:0] w;
        int pat;
        pat = $urandom_range(0, 4);
        x_dat = rnd_word();
        y_dat = rnd_word();
        z_dat = rnd_word();
        case (pat)
            1: y_dat[0] = 1'b0;
            2: y_dat[0] = 1'b1;
            3: y_dat = '1;
            4: begin w = rnd_word(); x_dat = w; y_dat = w; z_dat = w; end
            default: ;
        endcase
        if (phase == 0) begin
            {x_vld, y_vld, z_vld} = 3'b111;
            {p_rdy, q_rdy, r_rdy, bits_rdy} = 4'b1111;
        end else if (phase == 1) begin
            x_vld = ($urandom_range(0, 3) != 0);
            y_vld = ($urandom_range(0, 3) != 0);
            z_vld = ($urandom_range(0, 3) != 0);
            p_rdy = ($urandom_range(0, 3) != 0);
            q_rdy = ($urandom_range(0, 3) != 0);
            r_rdy = ($urandom_range(0, 3) != 0);
            bits_rdy = ($urandom_range(0, 2) != 0);
        end else begin
            {x_vld, y_vld, z_vld} = 3'b111;
            {p_rdy, q_rdy, r_rdy} = 3'b111;
            bits_rdy = 1'b0;
        end
    endtask

    function automatic logic [DW-1:0] maj(input logic [DW-1:0] a, b, c);
        return (a & b) | (b & c) | (a & c);
    endfunction

    task automatic step_check();
        bit go, room, flushing;
        string tg;
        // registered outputs vs model
        chk(p_vld == m_pv, "R9 p_vld", 64'(p_vld), 64'(m_pv));
        chk(q_vld == m_qv, "R9 q_vld", 64'(q_vld), 64'(m_qv));
        chk(r_vld == m_rv, "R9 r_vld", 64'(r_vld), 64'(m_rv));
        if (m_pv) chk(p_dat == m_p, "R5 p_dat", p_dat, m_p);
        tg = last_reduce ? "R4" : "R3";
        if (m_qv) begin
            chk(q_dat == m_q, {tg, " q_dat"}, q_dat, m_q);
            chk(q_dat[DW-1] == 1'b0, "R11 q_dat msb", 64'(q_dat[DW-1]), 64'(0));
        end
        if (m_rv) chk(r_dat == m_r, {tg, " r_dat"}, r_dat, m_r);
        chk(bits_vld == m_bv, "R8 bits_vld", 64'(bits_vld), 64'(m_bv));
        if (m_bv) chk(bits_dat == m_bw, "R6 R8 bits_dat", 64'(bits_dat), 64'(m_bw));
        if (bits_vld && bits_rdy) words_dut++;
        // expected acceptance
        room = (bq.size() < CAP);
        flushing = (fl > 0);
        go = x_vld && y_vld && z_vld && (!m_pv || p_rdy) && (!m_qv || q_rdy)
             && (!m_rv || r_rdy) && room && !flushing;
        tg = flushing ? "R7 x_rdy" : (!room ? "R10 x_rdy" : "R2 x_rdy");
        chk(x_rdy == go && y_rdy == go && z_rdy == go, tg,
            64'({x_rdy, y_rdy, z_rdy}), 64'({go, go, go}));
        if (m_bv && bits_rdy) words_model++;
        // advance model: group drain first
        if (bq.size() >= GROUP && (!m_bv || bits_rdy)) begin
            for (int i = 0; i < GROUP; i++) m_bw[i] = bq.pop_front();
            m_bv = 1;
        end else if (bits_rdy) begin
            m_bv = 0;
        end
        if (go) begin
            if (cnt % 2 == 0) begin
                m_p = x_dat;
                m_q = y_dat >> 1;
                m_r = y_dat[0] ? x_dat : '0;
                last_reduce = 0;
            end else begin
                m_p = maj(x_dat, y_dat, z_dat);
                m_q = (x_dat ^ y_dat ^ z_dat) >> 1;
                m_r = '0;
                bq.push_back(x_dat[0] ^ y_dat[0] ^ z_dat[0]);
                last_reduce = 1;
            end
            m_pv = 1; m_qv = 1; m_rv = 1;
            cnt--;
            if (cnt == 0) begin
                fl = FLUSH;
                f1 = m_p; f2 = m_q; f3 = m_r;
            end
        end else begin
            if (p_rdy) m_pv = 0;
            if (q_rdy) m_qv = 0;
            if (r_rdy) m_rv = 0;
            if (flushing && room) begin
                logic [DW-1:0] s;
                s = f1 ^ f2 ^ f3;
                bq.push_back(s[0]);
                f1 = maj(f1, f2, f3);
                f2 = s >> 1;
                f3 = '0;
                fl--;
                if (fl == 0) cnt = BUDGET;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!p_vld && !q_vld && !r_vld && !bits_vld, "R1 valids after reset",
            64'({p_vld, q_vld, r_vld, bits_vld}), 64'(0));
        chk(!x_rdy, "R1 no accept without valid", 64'(x_rdy), 64'(0));
        rst = 1'b0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            int ph;
            ph = (cyc < 1500) ? 0 : ((cyc < 4500) ? 1 : ((cyc < 4800) ? 2 : 0));
            @(negedge clk);
            drive(ph);
            #1;
            step_check();
        end
        chk(words_dut == words_model, "R6 groups emitted", 64'(words_dut), 64'(words_model));
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule